// File: doc/BRIEF.md
# Bit-Serial Threshold-Tree Classifier

This block assigns a feature vector to one of a small set of classes using an axis-parallel decision tree. No multiplier is involved. Each attribute reaches the block one bit per cycle on its own serial line, least significant bit first. A bank of threshold units subtracts a stored coefficient from its attribute, one bit at a time, with a single-bit adder and an inverted operand. Each unit turns the final carry into one node decision.

A second layer holds one programmable match unit per class. Each unit has a care mask and a value mask over the node decisions, so it encodes one root-to-leaf path of the tree. The result is a registered one-hot class word, qualified by a one-cycle valid pulse. Thresholds and masks are loaded through a serial configuration chain that shifts only while a configuration enable is high. Frames can be streamed back to back with no idle cycle between them.

Top module: `dtree_serial_classifier`

## Requirements
- R1: While `rstN` is low and after its release, `resultValid` is 0 and `classFlags` is 0 until the first result.
- R2: While `cfgEn` is high, each cycle shifts `cfgBit` into a 144-bit chain, and the first bit sent ends at position 0 after 144 shifts. Node n's threshold sits at positions 10n..10n+9, LSB at the lower position. Class c's care bit for node j is at 90+18c+j, and its value bit for node j is at 99+18c+j.
- R3: Node n's decision is 1 exactly when the unsigned 10-bit attribute on `attrBits[n]` is greater than or equal to node n's threshold. Each attribute is sent LSB first over 10 cycles, and bit 0 is sent in the cycle in which `frameStart` is accepted.
- R4: Class c matches when every node j whose care bit is 1 has a decision equal to its value bit. Nodes whose care bit is 0 are ignored, so a class with an all-zero care mask always matches.
- R5: When several classes match, only the lowest-index class is flagged. `classFlags` is always one-hot or zero, and it is zero when no class matches.
- R6: `resultValid` is a one-cycle pulse that appears two cycles after the cycle carrying attribute bit 9, with `classFlags` valid in the same cycle. `classFlags` holds its value until the next result.
- R7: A `frameStart` in the cycle right after a frame's bit 9 is accepted, so back-to-back frames each produce a result 10 cycles apart.
- R8: A `frameStart` raised while `cfgEn` is high is ignored and produces no result.
- R9: A `frameStart` raised during bits 1..9 of a frame in progress is ignored. The running frame completes unchanged, and no extra result appears.
- R10: Raising `cfgEn` during a frame aborts that frame: no result appears for it, and `classFlags` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Configuration shift enable |
| cfgBit | input | 1 | Serial configuration data |
| frameStart | input | 1 | Marks the cycle carrying attribute bit 0 |
| attrBits | input | 9 | One serial attribute bit per node, LSB first |
| resultValid | output | 1 | One-cycle result strobe |
| classFlags | output | 3 | One-hot class result |

## Verification
The bench aims at equality, at off-by-one attributes and at thresholds of 0 and 1023. A wrong carry preset or a reversed operand would make these tie cases decide wrongly. Overlapping class masks expose a broken priority as a two-hot word or as the wrong winner. Back-to-back frames catch a control path that needs a bubble or lets the carry leak between frames. Stray frame starts during a frame or during configuration, and a configuration started mid-frame, catch a design that restarts, emits a spurious pulse or disturbs the held flags.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // widest bit index the control can address
  localparam int STRB_IDX_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                  sample;  // a serial bit is present this cycle
    logic                  firstD;  // registered: stage holds bit 0
    logic                  lastD;   // registered: stage holds last bit, decisions valid
    logic [STRB_IDX_W-1:0] bitIdx;  // index of the bit present this cycle
  } dtc_strobe_t;
endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
#(
  parameter int COEF_W = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        cfgEn,
  output dtc_strobe_t strb
);
  localparam int CNT_W = $clog2(COEF_W + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             firstQ, lastQ;
  logic             goStart, sample, atLast;
  logic [CNT_W-1:0] idx;

  // R8 R9: a start is only taken when idle and not configuring
  assign goStart = frameStart && !cfgEn && !busy;
  assign idx     = goStart ? '0 : cnt;
  assign sample  = !cfgEn && (goStart || busy);
  assign atLast  = sample && (idx == CNT_W'(COEF_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      firstQ <= 1'b0;
      lastQ  <= 1'b0;
    end else if (cfgEn) begin
      // R10: configuration aborts any frame in flight
      busy   <= 1'b0;
      cnt    <= '0;
      firstQ <= 1'b0;
      lastQ  <= 1'b0;
    end else begin
      firstQ <= goStart;
      lastQ  <= atLast;
      if (goStart) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
      end else if (busy) begin
        if (cnt == CNT_W'(COEF_W - 1)) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign strb.sample = sample;
  assign strb.firstD = firstQ;
  assign strb.lastD  = lastQ;
  assign strb.bitIdx = STRB_IDX_W'(idx);

  // R9: a start strobe inside a running frame does not restart the count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && frameStart && !cfgEn && cnt != CNT_W'(COEF_W - 1))
      |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/dtc_tlu.sv
module dtc_tlu
  import dtc_pkg::*;
#(
  parameter int COEF_W    = 10,
  parameter int NUM_NODES = 9,
  parameter int LANE      = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 attrBit,
  input  logic [COEF_W-1:0]    coef,
  input  dtc_strobe_t          strb,
  output logic [NUM_NODES-1:0] busOut
);
  logic aQ, tQ, carryQ;
  logic thrBit, carryIn, carryOut;

  always_comb begin
    thrBit = 1'b0;
    for (int i = 0; i < COEF_W; i++)
      if (strb.bitIdx == STRB_IDX_W'(i)) thrBit = coef[i];
  end

  // R3: attr + ~thr + 1, carry out set means attr >= thr
  assign carryIn  = strb.firstD ? 1'b1 : carryQ;
  assign carryOut = (aQ & tQ) | (aQ & carryIn) | (tQ & carryIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ     <= 1'b0;
      tQ     <= 1'b0;
      carryQ <= 1'b0;
    end else begin
      if (strb.sample) begin
        aQ <= attrBit;
        tQ <= ~thrBit;
      end
      carryQ <= carryOut;
    end
  end

  // output enable onto the shared decision bus: drive own lane only when enabled
  always_comb begin
    busOut = '0;
    if (strb.lastD) busOut[LANE] = carryOut;
  end
endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int NUM_NODES   = 9,
  parameter int COEF_W      = 10,
  parameter int NUM_CLASSES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgEn,
  input  logic                   cfgBit,
  input  logic [NUM_NODES-1:0]   attrBits,
  input  dtc_strobe_t            strb,
  output logic [NUM_CLASSES-1:0] classFlags,
  output logic                   resultValid
);
  localparam int THR_BITS  = NUM_NODES * COEF_W;
  localparam int MASK_BITS = NUM_CLASSES * 2 * NUM_NODES;
  localparam int CFG_LEN   = THR_BITS + MASK_BITS;

  logic [CFG_LEN-1:0]     cfgQ;
  logic [NUM_NODES-1:0]   laneDrive [NUM_NODES];
  logic [NUM_NODES-1:0]   decBus;
  logic [NUM_CLASSES-1:0] match, pick;
  logic [NUM_CLASSES-1:0] flagsQ;
  logic                   validQ;

  // R2: serial chain, first bit sent ends at position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgEn) cfgQ <= {cfgBit, cfgQ[CFG_LEN-1:1]};
  end

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_tlu
    dtc_tlu #(.COEF_W(COEF_W), .NUM_NODES(NUM_NODES), .LANE(n)) u_tlu (
      .clk     (clk),
      .rstN    (rstN),
      .attrBit (attrBits[n]),
      .coef    (cfgQ[n*COEF_W +: COEF_W]),
      .strb    (strb),
      .busOut  (laneDrive[n])
    );
  end

  always_comb begin
    decBus = '0;
    for (int n = 0; n < NUM_NODES; n++) decBus = decBus | laneDrive[n];
  end

  // R4: each class is one care/value path pattern
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [NUM_NODES-1:0] care, val;
    assign care     = cfgQ[THR_BITS + c*2*NUM_NODES +: NUM_NODES];
    assign val      = cfgQ[THR_BITS + c*2*NUM_NODES + NUM_NODES +: NUM_NODES];
    assign match[c] = &(~care | ~(decBus ^ val));
  end

  // R5: lowest index wins
  always_comb begin
    pick = '0;
    for (int c = NUM_CLASSES - 1; c >= 0; c--)
      if (match[c]) pick = NUM_CLASSES'(1) << c;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.lastD;
      if (strb.lastD) flagsQ <= pick;
    end
  end

  assign classFlags  = flagsQ;
  assign resultValid = validQ;

  a_r5_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(classFlags));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  a_r8_cfg_silences: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |-> ##2 !resultValid);
endmodule

// File: rtl/dtree_serial_classifier.sv
module dtree_serial_classifier
  import dtc_pkg::*;
#(
  parameter int NUM_NODES   = 9,
  parameter int COEF_W      = 10,
  parameter int NUM_CLASSES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgEn,
  input  logic                   cfgBit,
  input  logic                   frameStart,
  input  logic [NUM_NODES-1:0]   attrBits,
  output logic                   resultValid,
  output logic [NUM_CLASSES-1:0] classFlags
);
  dtc_strobe_t strb;

  dtc_ctrl #(.COEF_W(COEF_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .cfgEn      (cfgEn),
    .strb       (strb)
  );

  dtc_datapath #(
    .NUM_NODES   (NUM_NODES),
    .COEF_W      (COEF_W),
    .NUM_CLASSES (NUM_CLASSES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cfgEn       (cfgEn),
    .cfgBit      (cfgBit),
    .attrBits    (attrBits),
    .strb        (strb),
    .classFlags  (classFlags),
    .resultValid (resultValid)
  );
endmodule

// File: tb/dtree_serial_classifier_tb.sv
module dtree_serial_classifier_tb;
  localparam int NN = 9;
  localparam int CW = 10;
  localparam int NC = 3;
  localparam int CFG_LEN = NN*CW + NC*2*NN;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic          cfgEn = 1'b0, cfgBit = 1'b0, frameStart = 1'b0;
  logic [NN-1:0] attrBits = '0;
  logic          resultValid;
  logic [NC-1:0] classFlags;

  dtree_serial_classifier u_dut (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .frameStart(frameStart), .attrBits(attrBits),
    .resultValid(resultValid), .classFlags(classFlags)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int testsRun = 0, testsFailed = 0;
  int            qT[$];
  logic [NC-1:0] qF[$];
  string         qTag[$];
  logic [NC-1:0] lastFlags = '0;
  bit            checking = 0;

  logic [CW-1:0] thr [NN];
  logic [NN-1:0] care [NC];
  logic [NN-1:0] val [NC];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: decisions, path match, priority
  function automatic logic [NC-1:0] refFlags(input logic [NN-1:0][CW-1:0] a);
    logic [NN-1:0] d;
    logic [NC-1:0] r;
    r = '0;
    for (int n = 0; n < NN; n++) d[n] = (a[n] >= thr[n]);
    for (int c = 0; c < NC; c++)
      if (r == '0 && (((d ~^ val[c]) | ~care[c]) == '1)) r[c] = 1'b1;
    return r;
  endfunction

  // per-cycle comparison against the expected result schedule
  always @(negedge clk) begin
    automatic bit expV;
    if (checking) begin
      expV = (qT.size() > 0 && qT[0] == cyc);
      check(resultValid === expV, "R6", "resultValid", int'(resultValid), int'(expV));
      if (expV) begin
        if (resultValid === 1'b1)
          check(classFlags === qF[0], qTag[0], "classFlags", int'(classFlags), int'(qF[0]));
        lastFlags = qF[0];
        void'(qT.pop_front()); void'(qF.pop_front()); void'(qTag.pop_front());
      end else begin
        check(classFlags === lastFlags, "R6", "held classFlags", int'(classFlags), int'(lastFlags));
      end
      while (qT.size() > 0 && qT[0] < cyc) begin
        void'(qT.pop_front()); void'(qF.pop_front()); void'(qTag.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameStart = 1'b0;
      attrBits   = '0;
    end
  endtask

  task automatic sendFrame(input logic [NN-1:0][CW-1:0] a, input string tag,
                           input int extraStartAt, input int abortAfter);
    int nb;
    nb = (abortAfter >= 0) ? abortAfter : CW;
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      frameStart = (b == 0) || (b == extraStartAt);
      for (int n = 0; n < NN; n++) attrBits[n] = a[n][b];
      if (b == 0 && abortAfter < 0) begin
        qT.push_back(cyc + 11);
        qF.push_back(refFlags(a));
        qTag.push_back(tag);
      end
    end
  endtask

  task automatic loadCfg(input int fsAt);
    logic [CFG_LEN-1:0] vec;
    for (int n = 0; n < NN; n++) vec[n*CW +: CW] = thr[n];
    for (int c = 0; c < NC; c++) begin
      vec[NN*CW + c*2*NN +: NN]      = care[c];
      vec[NN*CW + c*2*NN + NN +: NN] = val[c];
    end
    for (int k = 0; k < CFG_LEN; k++) begin
      @(negedge clk);
      cfgEn      = 1'b1;
      cfgBit     = vec[k];
      frameStart = (k == fsAt);
      attrBits   = NN'($urandom);
    end
    @(negedge clk);
    cfgEn = 1'b0; cfgBit = 1'b0; frameStart = 1'b0; attrBits = '0;
  endtask

  function automatic logic [NN-1:0][CW-1:0] randAttr();
    logic [NN-1:0][CW-1:0] a;
    for (int n = 0; n < NN; n++) a[n] = CW'($urandom);
    return a;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [NN-1:0][CW-1:0] a;
    repeat (4) @(negedge clk);
    check(resultValid === 1'b0, "R1", "reset resultValid", int'(resultValid), 0);
    check(classFlags === '0, "R1", "reset classFlags", int'(classFlags), 0);
    rstN = 1'b1;
    checking = 1;

    // configuration A: edge thresholds, overlapping class paths
    thr[0] = 10'd512; thr[1] = 10'd300; thr[2] = 10'd1023; thr[3] = 10'd0;
    thr[4] = 10'd1;   thr[5] = 10'd700; thr[6] = 10'd100;  thr[7] = 10'd999;
    thr[8] = 10'd450;
    care[0] = 9'b000000011; val[0] = 9'b000000001;
    care[1] = 9'b000000101; val[1] = 9'b000000101;
    care[2] = 9'b000000000; val[2] = 9'b000000000;
    loadCfg(-1);
    idle(3);

    for (int n = 0; n < NN; n++) a[n] = '0;
    sendFrame(a, "R3 zero", -1, -1); idle(2);
    for (int n = 0; n < NN; n++) a[n] = thr[n];
    sendFrame(a, "R3 equal", -1, -1); idle(2);
    for (int n = 0; n < NN; n++) a[n] = thr[n] - 10'd1;
    sendFrame(a, "R3 below", -1, -1); idle(2);
    for (int n = 0; n < NN; n++) a[n] = 10'd1023;
    sendFrame(a, "R3 max", -1, -1); idle(2);
    a = randAttr(); a[0] = thr[0]; a[1] = thr[1] - 10'd1; a[2] = 10'd1023;
    sendFrame(a, "R5 priority", -1, -1); idle(2);
    a = randAttr(); a[0] = thr[0] + 10'd1; a[1] = thr[1]; a[2] = 10'd1023;
    sendFrame(a, "R4 path", -1, -1); idle(2);
    a = randAttr(); a[0] = thr[0] - 10'd1;
    sendFrame(a, "R4 default", -1, -1); idle(2);

    // R7: back-to-back frames, no bubble
    for (int i = 0; i < 20; i++) sendFrame(randAttr(), "R7", -1, -1);
    idle(15);

    // R9: stray start mid-frame
    sendFrame(randAttr(), "R9", 4, -1);
    idle(15);

    // R8: start during configuration (same config reloaded)
    loadCfg(20);
    idle(15);

    // configuration B
    for (int n = 0; n < NN; n++) thr[n] = CW'($urandom);
    care[0] = 9'b110000000; val[0] = 9'b100000000;
    care[1] = 9'b000011000; val[1] = 9'b000010000;
    care[2] = 9'b000100000; val[2] = 9'b000000000;
    loadCfg(-1);
    idle(3);
    for (int i = 0; i < 12; i++) begin
      sendFrame(randAttr(), "R2", -1, -1);
      if (i % 3 == 0) idle(1);
    end
    idle(15);

    // R10: configuration raised mid-frame aborts it
    sendFrame(randAttr(), "R10", -1, 5);
    loadCfg(-1);
    idle(15);
    sendFrame(randAttr(), "R10 recovery", -1, -1);
    idle(15);

    check(qT.size() == 0, "R6", "pending results", qT.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule